// File: doc/BRIEF.md
# Fetch Target Predictor with Unconditional-Branch Folding

This block sits in the instruction fetch stage and is looked up with the fetch PC in the same cycle that the PC is presented. It holds a direct-mapped, tagged table of branch records. Each record keeps the branch's predicted target, a taken bit, an unconditional flag and the instruction word found at the target. A hit on a taken record steers fetch to the stored target, so the redirect costs no stall. A hit on a taken unconditional branch goes further. The block hands out the stored target instruction in place of the branch and steers fetch to the word after the target. The branch is folded out of the pipeline at zero cycle cost.

Branch resolution writes records back through an update port. A taken branch always writes its record, and in doing so replaces whatever record shared the same index. A not-taken branch only rewrites a record it already hits. A not-taken branch that misses leaves the table untouched. Lookup is purely combinational from the stored state. An update is committed at the clock edge that samples it. A lookup in the same cycle therefore still sees the old record, and the new one is visible from the following cycle.

There are no streaming payloads here. The lookup is a per-cycle control path, and the update port is a single valid strobe with no ready. Every update is accepted in the cycle it is offered, and neither port ever applies back-pressure.

Top module: `btb_fold`

## Requirements
- R1: While reset is asserted (`rst_n` low) every record is invalidated. After reset, any lookup reports `lk_hit`=0, `lk_fold_valid`=0 and `lk_next_pc`=`lk_pc`+4.
- R2: The table index is `lk_pc[IDX_W+1:2]` and the tag is `lk_pc[PC_W-1:IDX_W+2]`, with IDX_W = log2(ENTRIES) (ENTRIES=16 by default). A hit needs a valid record whose stored tag equals the tag. A PC with the same index but a different tag misses.
- R3: On a miss, `lk_next_pc` = `lk_pc`+4, `lk_fold_valid`=0 and `lk_fold_instr`=0.
- R4: An update with `upd_taken`=1 writes the record for `upd_pc`. From the next cycle on, a lookup of that PC hits. If the record is conditional (`upd_uncond`=0), `lk_next_pc` equals the stored target.
- R5: A lookup that hits a record that is both taken and unconditional sets `lk_fold_valid`=1. In that case `lk_fold_instr` is the stored target instruction and `lk_next_pc` = target+4.
- R6: `lk_fold_valid` is 1 only on a hit of a taken unconditional record. Whenever `lk_fold_valid` is 0, `lk_fold_instr` is 0.
- R7: A not-taken update whose PC misses allocates nothing. The table, including a different-tag record at the same index, is unchanged.
- R8: A not-taken update whose PC hits rewrites the record's taken bit to 0. Later lookups still hit, but give `lk_next_pc` = `lk_pc`+4.
- R9: A taken update overwrites the target of a hitting record. It replaces a different-tag record at the same index.
- R10: A lookup in the same cycle as an update to its index returns the old contents. The new contents appear in the next cycle.
- R11: Lookup is combinational: the outputs reflect `lk_pc` in the same cycle, with no registered stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch PC looked up this cycle |
| lk_hit | output | 1 | Valid record with matching tag |
| lk_next_pc | output | PC_W | Predicted next fetch PC |
| lk_fold_valid | output | 1 | Branch folded; use lk_fold_instr in its place |
| lk_fold_instr | output | INS_W | Stored target instruction when folding, else 0 |
| upd_valid | input | 1 | Resolution update strobe, always accepted |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_target | input | PC_W | Resolved target address |
| upd_instr | input | INS_W | Instruction word at the target |
| upd_taken | input | 1 | Branch was taken |
| upd_uncond | input | 1 | Branch is unconditional |

## Verification
Lookup results are due in the same cycle as `lk_pc`, with no register in the path. The effect of an update is due exactly one clock edge after the cycle in which `upd_valid` is sampled. The bench drives every input just after a falling edge and samples outputs one nanosecond later, well before the next rising edge. The same-cycle case is checked twice: once before the rising edge that commits the update, where the old result is expected, and again after it, where the new result is expected.

// File: rtl/btb_fold_pkg.sv
package btb_fold_pkg;
  typedef struct packed {
    logic vld;
    logic taken;
    logic uncond;
  } btb_flags_t;
endpackage

// File: rtl/btb_index.sv
module btb_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  logic unused_lo;
  assign unused_lo = ^pc[1:0];
  assign idx = pc[IDX_W+1:2];
  assign tag = pc[PC_W-1:IDX_W+2];
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_fold_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26,
  parameter int PC_W    = 32,
  parameter int INS_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic [INS_W-1:0] wr_ins,
  input  logic             wr_taken,
  input  logic             wr_uncond,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output btb_flags_t       ra_flags,
  output logic [PC_W-1:0]  ra_tgt,
  output logic [INS_W-1:0] ra_ins,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output btb_flags_t       rb_flags
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] taken_q;
  logic [ENTRIES-1:0] uncond_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [INS_W-1:0]   ins_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e]    <= 1'b0;
        taken_q[e]  <= 1'b0;
        uncond_q[e] <= 1'b0;
      end else if (sel) begin
        vld_q[e]    <= 1'b1;
        taken_q[e]  <= wr_taken;
        uncond_q[e] <= wr_uncond;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e] <= wr_tag;
        tgt_q[e] <= wr_tgt;
        ins_q[e] <= wr_ins;
      end
    end
  end

  assign ra_tag   = tag_q[ra_idx];
  assign ra_tgt   = tgt_q[ra_idx];
  assign ra_ins   = ins_q[ra_idx];
  assign ra_flags = '{vld: vld_q[ra_idx], taken: taken_q[ra_idx], uncond: uncond_q[ra_idx]};
  assign rb_tag   = tag_q[rb_idx];
  assign rb_flags = '{vld: vld_q[rb_idx], taken: taken_q[rb_idx], uncond: uncond_q[rb_idx]};

  // R1: reset leaves no valid record
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (vld_q == '0));
  // R4: a committed write makes its record valid
  p_write_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
  // R7: without a write the valid bits never change
  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/btb_select.sv
module btb_select #(
  parameter int PC_W  = 32,
  parameter int INS_W = 32
) (
  input  logic [PC_W-1:0]  pc,
  input  logic             hit,
  input  logic             taken,
  input  logic             uncond,
  input  logic [PC_W-1:0]  tgt,
  input  logic [INS_W-1:0] ins,
  output logic [PC_W-1:0]  next_pc,
  output logic             fold_valid,
  output logic [INS_W-1:0] fold_ins
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);
  logic redirect;

  always_comb begin
    redirect   = hit && taken;
    fold_valid = redirect && uncond;
    fold_ins   = fold_valid ? ins : '0;
    if (fold_valid)    next_pc = tgt + STEP;
    else if (redirect) next_pc = tgt;
    else               next_pc = pc + STEP;
  end
endmodule

// File: rtl/btb_fold.sv
module btb_fold
  import btb_fold_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int INS_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_hit,
  output logic [PC_W-1:0]  lk_next_pc,
  output logic             lk_fold_valid,
  output logic [INS_W-1:0] lk_fold_instr,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [PC_W-1:0]  upd_target,
  input  logic [INS_W-1:0] upd_instr,
  input  logic             upd_taken,
  input  logic             upd_uncond
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag, ra_tag, rb_tag;
  btb_flags_t       ra_flags, rb_flags;
  logic [PC_W-1:0]  ra_tgt;
  logic [INS_W-1:0] ra_ins;
  logic             up_hit, wr_en;

  btb_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_index (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
  btb_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_index (
    .pc(upd_pc), .idx(up_idx), .tag(up_tag));

  assign up_hit = rb_flags.vld && (rb_tag == up_tag);
  assign wr_en  = upd_valid && (upd_taken || up_hit);

  btb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
              .PC_W(PC_W), .INS_W(INS_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(upd_target),
    .wr_ins(upd_instr), .wr_taken(upd_taken), .wr_uncond(upd_uncond),
    .ra_idx(lk_idx), .ra_tag(ra_tag), .ra_flags(ra_flags),
    .ra_tgt(ra_tgt), .ra_ins(ra_ins),
    .rb_idx(up_idx), .rb_tag(rb_tag), .rb_flags(rb_flags));

  assign lk_hit = ra_flags.vld && (ra_tag == lk_tag);

  btb_select #(.PC_W(PC_W), .INS_W(INS_W)) u_select (
    .pc(lk_pc), .hit(lk_hit), .taken(ra_flags.taken), .uncond(ra_flags.uncond),
    .tgt(ra_tgt), .ins(ra_ins),
    .next_pc(lk_next_pc), .fold_valid(lk_fold_valid), .fold_ins(lk_fold_instr));

  // R3: a miss falls through to the sequential PC without folding
  p_miss_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_next_pc == lk_pc + PC_W'(4)) && !lk_fold_valid);
  // R6: folding only ever happens on a hit
  p_fold_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fold_valid |-> lk_hit);
  // R6: no instruction is offered unless folding
  p_fold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fold_valid |-> (lk_fold_instr == '0));
endmodule

// File: tb/btb_fold_bench.sv
module btb_fold_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_hit;
  logic [31:0] lk_next_pc;
  logic        lk_fold_valid;
  logic [31:0] lk_fold_instr;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0, upd_instr = '0;
  logic        upd_taken = 1'b0, upd_uncond = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  btb_fold u_btb_fold (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_next_pc(lk_next_pc), .lk_fold_valid(lk_fold_valid),
    .lk_fold_instr(lk_fold_instr), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_instr(upd_instr), .upd_taken(upd_taken),
    .upd_uncond(upd_uncond));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic look(input string req, input logic [31:0] pc, input logic hit,
                      input logic [31:0] nxt, input logic fold, input logic [31:0] ins);
    @(negedge clk);
    lk_pc = pc;
    #1;
    check({req, " hit"}, {31'd0, lk_hit}, {31'd0, hit});
    check({req, " next"}, lk_next_pc, nxt);
    check({req, " fold"}, {31'd0, lk_fold_valid}, {31'd0, fold});
    check({req, " instr"}, lk_fold_instr, ins);
  endtask

  task automatic update(input logic [31:0] pc, input logic [31:0] tgt, input logic [31:0] ins,
                        input logic tk, input logic un);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_instr = ins;
    upd_taken = tk; upd_uncond = un;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    look("R1 R3", 32'h100, 1'b0, 32'h104, 1'b0, 32'h0);
  endtask

  task automatic t_cond;
    update(32'h204, 32'h800, 32'h1111_1111, 1'b1, 1'b0);
    look("R4 R6", 32'h204, 1'b1, 32'h800, 1'b0, 32'h0);
  endtask

  task automatic t_fold;
    update(32'h308, 32'h900, 32'hDEAD_BEEF, 1'b1, 1'b1);
    look("R5", 32'h308, 1'b1, 32'h904, 1'b1, 32'hDEAD_BEEF);
  endtask

  task automatic t_alias;
    look("R2", 32'h1204, 1'b0, 32'h1208, 1'b0, 32'h0);
  endtask

  task automatic t_nt_miss;
    update(32'h1204, 32'hF00, 32'h2222_2222, 1'b0, 1'b0);
    look("R7 keep", 32'h204, 1'b1, 32'h800, 1'b0, 32'h0);
    look("R7 none", 32'h1204, 1'b0, 32'h1208, 1'b0, 32'h0);
  endtask

  task automatic t_nt_hit;
    update(32'h204, 32'h800, 32'h1111_1111, 1'b0, 1'b0);
    look("R8", 32'h204, 1'b1, 32'h208, 1'b0, 32'h0);
  endtask

  task automatic t_retarget;
    update(32'h204, 32'hA00, 32'h3333_3333, 1'b1, 1'b0);
    look("R9 retarget", 32'h204, 1'b1, 32'hA00, 1'b0, 32'h0);
    update(32'h1204, 32'hB00, 32'h4444_4444, 1'b1, 1'b0);
    look("R9 evicted", 32'h204, 1'b0, 32'h208, 1'b0, 32'h0);
    look("R9 replaced", 32'h1204, 1'b1, 32'hB00, 1'b0, 32'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h40C; upd_target = 32'hC00;
    upd_instr = 32'h5555_5555; upd_taken = 1'b1; upd_uncond = 1'b0;
    lk_pc = 32'h40C;
    #1;
    check("R10 R11 old hit", {31'd0, lk_hit}, 32'd0);
    check("R10 R11 old next", lk_next_pc, 32'h410);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    check("R10 new hit", {31'd0, lk_hit}, 32'd1);
    check("R10 new next", lk_next_pc, 32'hC00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cond();
    t_fold();
    t_alias();
    t_nt_miss();
    t_nt_hit();
    t_retarget();
    t_same_cycle();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule